// File: doc/BRIEF.md
# Boot Command Flow Sequencer

This block polices the order of commands in a serial boot-mode session. A packet framer upstream hands it one decoded command at a time: an opcode plus, for reads, an inclusive start and end address. The sequencer answers each accepted command with a one-byte status. A host must first set the clock frequency, then the baud rate, and then open the session. Only an open session may ask for memory reads, and a configuration input decides whether the session may be opened at all.

A read whose range lies on whole-block boundaries is acknowledged but held back. It runs only after the host echoes the acknowledge byte. It then drives one request per block, in ascending order, to a memory port with a valid/ready handshake. The address space has two regions. Addresses below a split point use small blocks and addresses at or above it use large blocks. With the defaults these are 8 KiB below 64 KiB and 32 KiB above it.

Top module: `boot_flow_seq`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` and `mem_req_valid` are 0, `cmd_ready` is 1, and the session is in its first setup step.
- R2: In the first setup step, only frequency setup (opcode 0x32) gets ACK (0x06). Baud setup (0x34), session open (0x38), read (0x15) and echo (0x06) get flow error 0xC3. After frequency setup, baud setup gets ACK, and session open and read still get 0xC3.
- R3: After both setup steps, session open with `prog_enable`=1 gets ACK and opens the session. Any read issued before the session is open gets 0xC3.
- R4: With `prog_enable`=0, session open gets 0xC3-distinct code 0xDC and the session stays closed, so a following read gets 0xC3. Frequency and baud setup keep getting ACK.
- R5: Once the session is open, frequency setup, baud setup, session open and echo get 0xC3.
- R6: A read gets ACK only when three conditions hold: the start is aligned to the block size of its own region, end+1 is aligned to the block size of the end's region, and start <= end. Small blocks apply below `SPLIT`, large blocks at or above it. Any other read gets address error 0xC5 and leaves the state unchanged.
- R7: After a read ACK, no memory request is made until an echo (0x06) is accepted, and the echo itself produces no response. Any other known command while the read is pending gets 0xC3 and cancels the read.
- R8: After the echo, one request per block is driven in ascending order. Each request carries the block base, `mem_req_large`=1 for large-region blocks, and `mem_req_last`=1 on the final block. A request holds steady while `mem_req_ready` is 0. After the last block is accepted, the session returns to waiting for commands.
- R9: `cmd_ready` is 0 while block requests are being driven.
- R10: An opcode outside the five known ones gets 0xC1 and leaves the state unchanged, including a pending read.
- R11: A response appears exactly one cycle after the accepting clock edge and lasts one cycle.
- R12: Asserting reset in the middle of a session returns the sequencer to the first setup step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_enable | input | 1 | 1 permits the session to be opened |
| cmd_valid | input | 1 | Decoded command present |
| cmd_ready | output | 1 | Sequencer accepts a command this cycle |
| cmd_code | input | 8 | Command opcode |
| cmd_start | input | ADDR_W | Read range first byte address |
| cmd_end | input | ADDR_W | Read range last byte address (inclusive) |
| rsp_valid | output | 1 | Status byte valid (one cycle) |
| rsp_code | output | 8 | Status byte |
| mem_req_valid | output | 1 | Block read request valid |
| mem_req_ready | input | 1 | Memory port takes the request |
| mem_req_addr | output | ADDR_W | Base address of the requested block |
| mem_req_large | output | 1 | Request is a large-region block |
| mem_req_last | output | 1 | Request is the final block of the range |

## Verification
The bench builds the sequencer with a 10-bit address space, 8-byte small blocks, 32-byte large blocks and the split at 256. These sizes bring the whole map into reach. Every read range whose start and end+1 are multiples of 8 is swept over the full space, which covers each large-block misalignment, reversed ranges, ranges crossing the split and the top address. Block walks over a few of these ranges, with stalls on the memory port, check every request address, size flag and last marker.

// File: rtl/boot_flow_pkg.sv
package boot_flow_pkg;

  // command opcodes
  localparam logic [7:0] OP_FREQ = 8'h32;
  localparam logic [7:0] OP_BAUD = 8'h34;
  localparam logic [7:0] OP_OPEN = 8'h38;
  localparam logic [7:0] OP_READ = 8'h15;
  localparam logic [7:0] OP_ECHO = 8'h06;

  // status bytes
  localparam logic [7:0] ST_ACK    = 8'h06;
  localparam logic [7:0] ST_FLOW   = 8'hC3;
  localparam logic [7:0] ST_LOCKED = 8'hDC;
  localparam logic [7:0] ST_ADDR   = 8'hC5;
  localparam logic [7:0] ST_BADCMD = 8'hC1;

  typedef enum logic [2:0] {
    PH_FREQ, // waiting for frequency setup
    PH_BAUD, // waiting for baud setup
    PH_OPEN, // waiting for session open
    PH_IDLE, // session open, waiting for commands
    PH_ECHO, // read acknowledged, waiting for echo
    PH_WALK  // driving block requests
  } phase_e;

endpackage

// File: rtl/boot_flow_range_check.sv
module boot_flow_range_check #(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned SMALL_LOG2 = 13,
  parameter int unsigned LARGE_LOG2 = 15,
  parameter int unsigned SPLIT      = 32'h1_0000
) (
  input  logic [ADDR_W-1:0] range_start,
  input  logic [ADDR_W-1:0] range_end,
  output logic              range_ok
);

  localparam logic [ADDR_W-1:0] SPLIT_A = ADDR_W'(SPLIT);

  logic            start_large;
  logic            end_large;
  logic [ADDR_W:0] end_p1;
  logic            start_ok;
  logic            end_ok;

  always_comb begin
    start_large = (range_start >= SPLIT_A);
    end_large   = (range_end >= SPLIT_A);
    end_p1      = {1'b0, range_end} + (ADDR_W+1)'(1);
    start_ok    = start_large ? (range_start[LARGE_LOG2-1:0] == '0)
                              : (range_start[SMALL_LOG2-1:0] == '0);
    end_ok      = end_large ? (end_p1[LARGE_LOG2-1:0] == '0)
                            : (end_p1[SMALL_LOG2-1:0] == '0);
    range_ok    = start_ok && end_ok && (range_start <= range_end);
  end

endmodule

// File: rtl/boot_flow_block_walker.sv
module boot_flow_block_walker #(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned SMALL_LOG2 = 13,
  parameter int unsigned LARGE_LOG2 = 15,
  parameter int unsigned SPLIT      = 32'h1_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_start,
  input  logic [ADDR_W-1:0] ld_end,
  input  logic              adv,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              blk_large,
  output logic              blk_last
);

  localparam logic [ADDR_W-1:0] SPLIT_A    = ADDR_W'(SPLIT);
  localparam logic [ADDR_W:0]   STEP_SMALL = (ADDR_W+1)'(1) << SMALL_LOG2;
  localparam logic [ADDR_W:0]   STEP_LARGE = (ADDR_W+1)'(1) << LARGE_LOG2;

  logic [ADDR_W:0] cur_q, cur_d;
  logic [ADDR_W:0] lim_q, lim_d;
  logic [ADDR_W:0] cur_next;

  always_comb begin
    blk_addr  = cur_q[ADDR_W-1:0];
    blk_large = (cur_q[ADDR_W-1:0] >= SPLIT_A);
    cur_next  = cur_q + (blk_large ? STEP_LARGE : STEP_SMALL);
    blk_last  = (cur_next == lim_q);
  end

  always_comb begin
    cur_d = cur_q;
    lim_d = lim_q;
    if (load) begin
      cur_d = {1'b0, ld_start};
      lim_d = {1'b0, ld_end} + (ADDR_W+1)'(1);
    end else if (adv) begin
      cur_d = cur_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      lim_q <= '0;
    end else if (load || adv) begin
      cur_q <= cur_d;
      lim_q <= lim_d;
    end
  end

endmodule

// File: rtl/boot_flow_seq.sv
module boot_flow_seq
  import boot_flow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned SMALL_LOG2 = 13,
  parameter int unsigned LARGE_LOG2 = 15,
  parameter int unsigned SPLIT      = 32'h1_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_enable,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_start,
  input  logic [ADDR_W-1:0] cmd_end,
  output logic              rsp_valid,
  output logic [7:0]        rsp_code,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_large,
  output logic              mem_req_last
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  phase_e     phase_q, phase_d;
  logic       rsp_valid_q, rsp_valid_d;
  logic [7:0] rsp_code_q, rsp_code_d;
  logic       accept;
  logic       range_ok;
  logic       walk_load;
  logic       walk_adv;
  logic       flow_err;

  boot_flow_range_check #(
    .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2),
    .LARGE_LOG2(LARGE_LOG2), .SPLIT(SPLIT)
  ) range_i (
    .range_start (cmd_start),
    .range_end   (cmd_end),
    .range_ok    (range_ok)
  );

  boot_flow_block_walker #(
    .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2),
    .LARGE_LOG2(LARGE_LOG2), .SPLIT(SPLIT)
  ) walker_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (walk_load),
    .ld_start  (cmd_start),
    .ld_end    (cmd_end),
    .adv       (walk_adv),
    .blk_addr  (mem_req_addr),
    .blk_large (mem_req_large),
    .blk_last  (mem_req_last)
  );

  assign cmd_ready     = (phase_q != PH_WALK);
  assign accept        = cmd_valid && cmd_ready;
  assign mem_req_valid = (phase_q == PH_WALK);
  assign walk_adv      = mem_req_valid && mem_req_ready;

  // next-state process
  always_comb begin
    phase_d     = phase_q;
    rsp_valid_d = 1'b0;
    rsp_code_d  = rsp_code_q;
    walk_load   = 1'b0;
    flow_err    = 1'b0;

    if (accept) begin
      rsp_valid_d = 1'b1;
      rsp_code_d  = ST_ACK;
      unique case (cmd_code)
        OP_FREQ: begin
          if (phase_q == PH_FREQ)                              phase_d = PH_BAUD;
          else if (phase_q != PH_BAUD && phase_q != PH_OPEN)   flow_err = 1'b1;
        end
        OP_BAUD: begin
          if (phase_q == PH_BAUD)      phase_d = PH_OPEN;
          else if (phase_q != PH_OPEN) flow_err = 1'b1;
        end
        OP_OPEN: begin
          if (phase_q != PH_OPEN)  flow_err = 1'b1;
          else if (prog_enable)    phase_d = PH_IDLE;
          else                     rsp_code_d = ST_LOCKED;
        end
        OP_READ: begin
          if (phase_q != PH_IDLE) begin
            flow_err = 1'b1;
          end else if (range_ok) begin
            phase_d   = PH_ECHO;
            walk_load = 1'b1;
          end else begin
            rsp_code_d = ST_ADDR;
          end
        end
        OP_ECHO: begin
          if (phase_q == PH_ECHO) begin
            rsp_valid_d = 1'b0;
            rsp_code_d  = rsp_code_q;
            phase_d     = PH_WALK;
          end else begin
            flow_err = 1'b1;
          end
        end
        default: rsp_code_d = ST_BADCMD;
      endcase

      if (flow_err) begin
        rsp_code_d = ST_FLOW;
        if (phase_q == PH_ECHO) phase_d = PH_IDLE;
      end
    end

    if (walk_adv && mem_req_last) phase_d = PH_IDLE;
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q     <= PH_FREQ;
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= ST_ACK;
    end else begin
      phase_q     <= phase_d;
      rsp_valid_q <= rsp_valid_d;
      if (accept) rsp_code_q <= rsp_code_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;

endmodule

// File: rtl/boot_flow_seq_chk.sv
module boot_flow_seq_chk
  import boot_flow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned SMALL_LOG2 = 13,
  parameter int unsigned LARGE_LOG2 = 15,
  parameter int unsigned SPLIT      = 32'h1_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_enable,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_code,
  input logic              rsp_valid,
  input logic [7:0]        rsp_code,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_large,
  input logic              mem_req_last
);

  localparam logic [ADDR_W-1:0] SPLIT_A = ADDR_W'(SPLIT);

  assert_rsp_follows_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_ready));

  assert_no_cmd_while_walking_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);

  assert_stall_holds_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_last)));

  assert_request_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_large ? (mem_req_addr[LARGE_LOG2-1:0] == '0)
                                     : (mem_req_addr[SMALL_LOG2-1:0] == '0)));

  assert_region_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_large == (mem_req_addr >= SPLIT_A)));

  assert_locked_open_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == ST_ACK) |->
      !($past(cmd_code) == OP_OPEN && !$past(prog_enable)));

endmodule

bind boot_flow_seq boot_flow_seq_chk #(
  .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2),
  .LARGE_LOG2(LARGE_LOG2), .SPLIT(SPLIT)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .prog_enable   (prog_enable),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_code      (cmd_code),
  .rsp_valid     (rsp_valid),
  .rsp_code      (rsp_code),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_large (mem_req_large),
  .mem_req_last  (mem_req_last)
);

// File: tb/boot_flow_seq_tb_top.sv
`timescale 1ns/1ps
module boot_flow_seq_tb_top;

  localparam int AW  = 10;
  localparam int SL  = 3;
  localparam int LL  = 5;
  localparam int SPL = 256;

  logic          clk;
  logic          rst_n;
  logic          prog_enable;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [7:0]    cmd_code;
  logic [AW-1:0] cmd_start;
  logic [AW-1:0] cmd_end;
  logic          rsp_valid;
  logic [7:0]    rsp_code;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_large;
  logic          mem_req_last;

  int tests;
  int fails;

  boot_flow_seq #(.ADDR_W(AW), .SMALL_LOG2(SL), .LARGE_LOG2(LL), .SPLIT(SPL)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_enable(prog_enable),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_start(cmd_start), .cmd_end(cmd_end),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_large(mem_req_large),
    .mem_req_last(mem_req_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int blk_size(input int a);
    return (a >= SPL) ? (1 << LL) : (1 << SL);
  endfunction

  function automatic bit range_good(input int s, input int e);
    return (s % blk_size(s) == 0) && ((e + 1) % blk_size(e) == 0) && (s <= e);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] code, input int s, input int e,
                       output logic v, output logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_start = AW'(s);
    cmd_end   = AW'(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    v = rsp_valid;
    c = rsp_code;
  endtask

  task automatic cmd_exp(input string tag, input logic [7:0] code,
                         input int s, input int e, input logic [7:0] exp);
    logic v;
    logic [7:0] c;
    issue(code, s, e, v, c);
    check({tag, " valid"}, int'(v), 1);
    check({tag, " code"}, int'(c), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    mem_req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // read a range: ACK, idle gap, optional junk opcode, echo, then walk
  task automatic walk(input string tag, input int s, input int e, input bit junk);
    logic v;
    logic [7:0] c;
    int cur;
    int n;
    bit stall;
    bit exp_last;
    cmd_exp({tag, " R7 read ack"}, 8'h15, s, e, 8'h06);
    @(negedge clk);
    check({tag, " R7 no request before echo"}, int'(mem_req_valid), 0);
    if (junk) cmd_exp({tag, " R10 unknown while pending"}, 8'h7E, 0, 0, 8'hC1);
    issue(8'h06, 0, 0, v, c);
    check({tag, " R7 echo silent"}, int'(v), 0);
    cur = s;
    n = 0;
    while (n < 600) begin
      stall = (n % 3 == 1);
      n++;
      mem_req_ready = !stall;
      exp_last = (cur + blk_size(cur) == e + 1);
      check({tag, " R8 valid"}, int'(mem_req_valid), 1);
      check({tag, " R9 cmd_ready low"}, int'(cmd_ready), 0);
      check({tag, " R8 addr"}, int'(mem_req_addr), cur);
      check({tag, " R8 large"}, int'(mem_req_large), (cur >= SPL) ? 1 : 0);
      check({tag, " R8 last"}, int'(mem_req_last), int'(exp_last));
      @(negedge clk);
      if (!stall) begin
        if (exp_last) break;
        cur += blk_size(cur);
      end
    end
    mem_req_ready = 1'b0;
    check({tag, " R8 walk ends"}, int'(mem_req_valid), 0);
    check({tag, " R8 back to waiting"}, int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    rst_n = 1'b0;
    prog_enable = 1'b0;
    cmd_valid = 1'b0;
    cmd_code = 8'h00;
    cmd_start = '0;
    cmd_end = '0;
    mem_req_ready = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 rsp_valid in reset", int'(rsp_valid), 0);
    check("R1 mem_req_valid in reset", int'(mem_req_valid), 0);
    do_reset();
    check("R1 rsp_valid after reset", int'(rsp_valid), 0);
    check("R1 mem_req_valid after reset", int'(mem_req_valid), 0);
    check("R1 cmd_ready after reset", int'(cmd_ready), 1);

    // setup order
    cmd_exp("R2 baud first", 8'h34, 0, 0, 8'hC3);
    @(negedge clk);
    check("R11 response lasts one cycle", int'(rsp_valid), 0);
    cmd_exp("R2 open first", 8'h38, 0, 0, 8'hC3);
    cmd_exp("R2 read first", 8'h15, 0, 7, 8'hC3);
    cmd_exp("R2 echo first", 8'h06, 0, 0, 8'hC3);
    cmd_exp("R2 freq", 8'h32, 0, 0, 8'h06);
    cmd_exp("R2 open skips baud", 8'h38, 0, 0, 8'hC3);
    cmd_exp("R2 read skips baud", 8'h15, 0, 7, 8'hC3);
    cmd_exp("R2 baud", 8'h34, 0, 0, 8'h06);
    cmd_exp("R3 read before open", 8'h15, 0, 7, 8'hC3);

    // programming disabled
    cmd_exp("R4 open refused", 8'h38, 0, 0, 8'hDC);
    cmd_exp("R4 read still closed", 8'h15, 0, 7, 8'hC3);
    cmd_exp("R4 freq still ok", 8'h32, 0, 0, 8'h06);
    cmd_exp("R4 baud still ok", 8'h34, 0, 0, 8'h06);
    cmd_exp("R10 unknown before open", 8'h7E, 0, 0, 8'hC1);
    cmd_exp("R4 open refused again", 8'h38, 0, 0, 8'hDC);

    prog_enable = 1'b1;
    cmd_exp("R3 open", 8'h38, 0, 0, 8'h06);
    cmd_exp("R5 freq after open", 8'h32, 0, 0, 8'hC3);
    cmd_exp("R5 baud after open", 8'h34, 0, 0, 8'hC3);
    cmd_exp("R5 open after open", 8'h38, 0, 0, 8'hC3);
    cmd_exp("R5 echo while idle", 8'h06, 0, 0, 8'hC3);
    cmd_exp("R10 unknown when open", 8'hA5, 0, 0, 8'hC1);

    // small-region misalignment, reversed range; state stays open
    cmd_exp("R6 start misaligned", 8'h15, 4, 31, 8'hC5);
    cmd_exp("R6 end misaligned", 8'h15, 0, 27, 8'hC5);
    cmd_exp("R6 reversed", 8'h15, 16, 7, 8'hC5);
    cmd_exp("R6 large end misaligned", 8'h15, 256, 271, 8'hC5);

    // pending read cancelled by another command
    cmd_exp("R7 read ack", 8'h15, 0, 15, 8'h06);
    cmd_exp("R7 cancel", 8'h34, 0, 0, 8'hC3);
    cmd_exp("R7 echo after cancel", 8'h06, 0, 0, 8'hC3);

    // block walks
    walk("small run", 0, 31, 1'b0);
    walk("split cross", 248, 287, 1'b1);
    walk("top block", 992, 1023, 1'b0);
    walk("single small", 240, 247, 1'b0);

    // sweep every 8-grained range over the whole space
    for (int si = 0; si < 128; si++) begin
      for (int ei = 0; ei < 128; ei++) begin
        int s;
        int e;
        s = si * 8;
        e = ei * 8 + 7;
        if (range_good(s, e)) begin
          cmd_exp("R6 sweep ack", 8'h15, s, e, 8'h06);
          cmd_exp("R7 sweep cancel", 8'h32, 0, 0, 8'hC3);
        end else begin
          cmd_exp("R6 sweep reject", 8'h15, s, e, 8'hC5);
        end
      end
    end

    // reset mid session
    cmd_exp("R12 read before reset", 8'h15, 0, 7, 8'h06);
    do_reset();
    check("R12 no response after reset", int'(rsp_valid), 0);
    cmd_exp("R12 read after reset", 8'h15, 0, 7, 8'hC3);
    cmd_exp("R12 open after reset", 8'h38, 0, 0, 8'hC3);
    cmd_exp("R12 freq after reset", 8'h32, 0, 0, 8'h06);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule